// File: doc/BRIEF.md
# Chroma 4:2:2 to 4:4:4 Upsampler for Receiver Video Path

This block sits after the TMDS decoders of a video receiver. Each accepted pixel arrives as three decoded channel words. The block always emits one 36-bit 4:4:4 pixel, made of 12-bit Y, Cb and Cr fields. Pixels already in 4:4:4 are passed on with only their bit depth aligned.

Pixels in 4:2:2 carry one 12-bit luma sample and one 12-bit chroma sample. Each sample is split into a low nibble on channel 0 and a high byte on another channel. The block joins these pieces again. It then supplies each pixel with the chroma component that pixel does not carry. In replicate mode that component is copied from the same pair. In interpolate mode it is a rounded average of the neighbouring co-sited pairs.

Samples narrower than 12 bits are moved up to the top of the field, with zeros filling the low bits. Timing flags travel down the same pipeline as the pixel data, so they stay aligned with it.

Top module: `ycc_upconv`

## Requirements
- R1: While reset is active and after it is released, out_valid, out_de, out_hs, out_vs, out_y, out_cb and out_cr are all zero until pixels arrive.
- R2: With cfg_422=0 and 12-bit depth (cfg_depth 2 or 3), out_y equals in_ch1, out_cb equals in_ch0 and out_cr equals in_ch2.
- R3: With cfg_422=0, cfg_depth selects the sample width: 0 means 8 bits, 1 means 10 bits, and 2 or 3 mean 12 bits. The low N bits of each channel are the sample. The sample is shifted up by 12-N and the low bits are filled with zeros. Channel bits above N are ignored.
- R4: With cfg_422=1, a pixel's luma is {in_ch1[7:0], in_ch0[3:0]} and its chroma is {in_ch2[7:0], in_ch0[7:4]}. Channel bits [11:8] are ignored.
- R5: With cfg_422=1 and a depth below 12 bits, the 12-N bits below each joined sample's top N bits are forced to zero.
- R6: In 4:2:2, the first pixel with in_de=1 after a sample with in_de=0 is even and carries Cb. After that, pixels alternate odd (Cr) and even (Cb).
- R7: With cfg_422=1 and cfg_interp=0, both pixels of a pair output the pair's own Cb and Cr.
- R8: With cfg_422=1 and cfg_interp=1, the even pixel outputs its pair's Cb and Cr. The odd pixel outputs (a+b+1)>>1 for each component, where a is its own pair's value and b is the next pair's value.
- R9: With cfg_422=1 and cfg_interp=1, the odd pixel of the last pair of a line uses its own pair's Cb and Cr.
- R10: Each accepted pixel k (in_valid=1) appears on the outputs after the edge that accepts pixel k+2. Its out_de, out_hs and out_vs come with it. out_valid is in_valid delayed by one clock.
- R11: An output pixel whose out_de is 0 has out_y, out_cb and out_cr all zero.
- R12: A clock with in_valid=0 leaves every output except out_valid unchanged and does not advance the pairing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_422 | input | 1 | 1: input is 4:2:2, 0: input is 4:4:4 |
| cfg_interp | input | 1 | 4:2:2 chroma fill: 0 replicate, 1 average |
| cfg_depth | input | 2 | Sample width: 0 = 8, 1 = 10, 2/3 = 12 bits |
| in_valid | input | 1 | Pixel strobe; the pipeline advances only when high |
| in_de | input | 1 | Active-video flag of the input pixel |
| in_hs | input | 1 | Horizontal sync of the input pixel |
| in_vs | input | 1 | Vertical sync of the input pixel |
| in_ch0 | input | CHW | Decoded channel 0 word |
| in_ch1 | input | CHW | Decoded channel 1 word |
| in_ch2 | input | CHW | Decoded channel 2 word |
| out_valid | output | 1 | Output pixel strobe |
| out_de | output | 1 | Delayed active-video flag |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_y | output | 12 | Luma, left-justified |
| out_cb | output | 12 | Blue-difference chroma, left-justified |
| out_cr | output | 12 | Red-difference chroma, left-justified |

## Verification
The design and its assertions take three things for granted about the inputs:
- In 4:2:2 mode, every active line holds an even number of pixels, so each even pixel has an odd partner.
- Each line is followed by at least one accepted blanking sample.
- The configuration inputs change only after at least three blanking samples, once the pipeline holds no active pixel.

The stimulus keeps within these limits. It builds lines of even length from 2 to 10 pixels. It ends each line with three blanking samples. It reprograms the configuration only after the third blanking sample of a new frame. Between pixels it inserts random gaps with in_valid low, and during those gaps it drives random values on the other inputs.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

    localparam int CW = 12;

    typedef logic [CW-1:0] comp_t;

    typedef enum logic [1:0] {
        DEPTH_8  = 2'd0,
        DEPTH_10 = 2'd1,
        DEPTH_12 = 2'd2,
        DEPTH_12B = 2'd3
    } depth_e;

    typedef struct packed {
        logic  de;
        logic  hs;
        logic  vs;
        logic  odd;
        comp_t y;
        comp_t c_a;
        comp_t c_b;
    } stage_t;

    typedef struct packed {
        stage_t s1;
        stage_t s2;
        comp_t  hold;
        logic   par;
        logic   vld;
        logic   o_de;
        logic   o_hs;
        logic   o_vs;
        comp_t  o_y;
        comp_t  o_cb;
        comp_t  o_cr;
    } state_t;

    function automatic int unsigned depth_bits(input logic [1:0] code);
        case (depth_e'(code))
            DEPTH_8:  return 8;
            DEPTH_10: return 10;
            default:  return 12;
        endcase
    endfunction

    function automatic comp_t round_avg(input comp_t a, input comp_t b);
        logic [CW:0] s;
        s = {1'b0, a} + {1'b0, b} + {{CW{1'b0}}, 1'b1};
        return s[CW:1];
    endfunction

endpackage

// File: rtl/ycc_unpack.sv
module ycc_unpack
    import ycc_pkg::*;
#(
    parameter int CHW = 12
) (
    input  logic [CHW-1:0] ch0,
    input  logic [CHW-1:0] ch1,
    input  logic [CHW-1:0] ch2,
    input  logic           mode422,
    input  logic [1:0]     depth,
    output comp_t          y,
    output comp_t          c_a,
    output comp_t          c_b
);
    localparam int NIB = 4;
    localparam int HI  = CW - NIB;

    int unsigned sh;
    comp_t       keep_mask;
    comp_t       jy;
    comp_t       jc;

    always_comb begin
        sh        = CW - depth_bits(depth);
        keep_mask = comp_t'({CW{1'b1}} << sh);
        jy        = {ch1[HI-1:0], ch0[NIB-1:0]} & keep_mask;
        jc        = {ch2[HI-1:0], ch0[2*NIB-1:NIB]} & keep_mask;
        if (mode422) begin
            y   = jy;
            c_a = jc;
            c_b = jc;
        end else begin
            y   = comp_t'(ch1[CW-1:0] << sh);
            c_a = comp_t'(ch0[CW-1:0] << sh);
            c_b = comp_t'(ch2[CW-1:0] << sh);
        end
    end

endmodule

// File: rtl/ycc_chroma.sv
module ycc_chroma
    import ycc_pkg::*;
(
    input  logic  mode422,
    input  logic  interp,
    input  logic  cur_odd,
    input  comp_t cur_ca,
    input  comp_t cur_cb,
    input  logic  nxt_de,
    input  logic  nxt_odd,
    input  comp_t nxt_ca,
    input  logic  nx2_de,
    input  comp_t nx2_ca,
    input  comp_t hold_cb,
    output comp_t out_cb,
    output comp_t out_cr
);
    logic next_pair;

    always_comb begin
        next_pair = nxt_de & ~nxt_odd;
        if (!mode422) begin
            out_cb = cur_ca;
            out_cr = cur_cb;
        end else if (!cur_odd) begin
            out_cb = cur_ca;
            out_cr = nxt_ca;
        end else begin
            out_cb = (interp && next_pair) ? round_avg(hold_cb, nxt_ca) : hold_cb;
            out_cr = (interp && next_pair && nx2_de) ? round_avg(cur_ca, nx2_ca) : cur_ca;
        end
    end

endmodule

// File: rtl/ycc_upconv.sv
module ycc_upconv
    import ycc_pkg::*;
#(
    parameter int CHW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_422,
    input  logic           cfg_interp,
    input  logic [1:0]     cfg_depth,
    input  logic           in_valid,
    input  logic           in_de,
    input  logic           in_hs,
    input  logic           in_vs,
    input  logic [CHW-1:0] in_ch0,
    input  logic [CHW-1:0] in_ch1,
    input  logic [CHW-1:0] in_ch2,
    output logic           out_valid,
    output logic           out_de,
    output logic           out_hs,
    output logic           out_vs,
    output logic [11:0]    out_y,
    output logic [11:0]    out_cb,
    output logic [11:0]    out_cr
);
    state_t st_d, st_q;
    stage_t x;
    comp_t  ux_y, ux_ca, ux_cb;
    comp_t  fill_cb, fill_cr;

    ycc_unpack #(.CHW(CHW)) u_unpack (
        .ch0     (in_ch0),
        .ch1     (in_ch1),
        .ch2     (in_ch2),
        .mode422 (cfg_422),
        .depth   (cfg_depth),
        .y       (ux_y),
        .c_a     (ux_ca),
        .c_b     (ux_cb)
    );

    ycc_chroma u_chroma (
        .mode422 (cfg_422),
        .interp  (cfg_interp),
        .cur_odd (st_q.s2.odd),
        .cur_ca  (st_q.s2.c_a),
        .cur_cb  (st_q.s2.c_b),
        .nxt_de  (st_q.s1.de),
        .nxt_odd (st_q.s1.odd),
        .nxt_ca  (st_q.s1.c_a),
        .nx2_de  (x.de),
        .nx2_ca  (x.c_a),
        .hold_cb (st_q.hold),
        .out_cb  (fill_cb),
        .out_cr  (fill_cr)
    );

    always_comb begin
        x.de  = in_de;
        x.hs  = in_hs;
        x.vs  = in_vs;
        x.odd = in_de & st_q.par;
        x.y   = ux_y;
        x.c_a = ux_ca;
        x.c_b = ux_cb;

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.par = in_de & ~st_q.par;
            st_d.s1  = x;
            st_d.s2  = st_q.s1;
            if (st_q.s1.odd) begin
                st_d.hold = st_q.s2.c_a;
            end
            st_d.o_de = st_q.s2.de;
            st_d.o_hs = st_q.s2.hs;
            st_d.o_vs = st_q.s2.vs;
            st_d.o_y  = st_q.s2.de ? st_q.s2.y : '0;
            st_d.o_cb = st_q.s2.de ? fill_cb   : '0;
            st_d.o_cr = st_q.s2.de ? fill_cr   : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_de    = st_q.o_de;
    assign out_hs    = st_q.o_hs;
    assign out_vs    = st_q.o_vs;
    assign out_y     = st_q.o_y;
    assign out_cb    = st_q.o_cb;
    assign out_cr    = st_q.o_cr;

    AST_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10
    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_y) && $stable(out_cb) && $stable(out_cr) && $stable(out_de)); // R12
    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !st_q.s2.de |=> out_y == '0 && out_cb == '0 && out_cr == '0); // R11
    AST_LINE_START_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_de && !st_q.s1.de |=> !st_q.s1.odd); // R6
    AST_PAIR_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_de && st_q.s1.de |=> st_q.s1.odd != $past(st_q.s1.odd)); // R6

endmodule

// File: tb/tb_ycc_upconv.sv
module tb_ycc_upconv;
    localparam int MAXS = 4096;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_422, cfg_interp;
    logic [1:0]  cfg_depth;
    logic        in_valid, in_de, in_hs, in_vs;
    logic [11:0] in_ch0, in_ch1, in_ch2;
    logic        out_valid, out_de, out_hs, out_vs;
    logic [11:0] out_y, out_cb, out_cr;

    always #10 clk = ~clk;

    ycc_upconv dut (
        .clk(clk), .rst_n(rst_n), .cfg_422(cfg_422), .cfg_interp(cfg_interp),
        .cfg_depth(cfg_depth), .in_valid(in_valid), .in_de(in_de), .in_hs(in_hs),
        .in_vs(in_vs), .in_ch0(in_ch0), .in_ch1(in_ch1), .in_ch2(in_ch2),
        .out_valid(out_valid), .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs),
        .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
    );

    bit        a_de[MAXS], a_hs[MAXS], a_vs[MAXS], a_par[MAXS], a_m422[MAXS], a_int[MAXS];
    int        a_dep[MAXS];
    bit [11:0] a_y[MAXS], a_ca[MAXS], a_cb[MAXS];
    int        ns = 0;
    int        nchk = 0, nerr = 0;
    bit        par_b = 1'b0;
    bit        done = 1'b0;
    int        pat = 0;
    logic [38:0] snap;

    function automatic int dbits(input logic [1:0] c);
        return (c == 2'd0) ? 8 : (c == 2'd1) ? 10 : 12;
    endfunction

    function automatic bit [11:0] avg(input bit [11:0] a, input bit [11:0] b);
        bit [12:0] s;
        s = {1'b0, a} + {1'b0, b} + 13'd1;
        return s[12:1];
    endfunction

    function automatic bit [11:0] sample(input int d);
        bit [11:0] v;
        if (pat == 1)      v = 12'hFFF;
        else if (pat == 2) v = 12'(ns & 1);
        else               v = 12'($urandom);
        return v & 12'((1 << d) - 1);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [38:0] act, input logic [38:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic calc(input int j, output logic [35:0] e, output string tag);
        bit [11:0] cb, cr;
        if (!a_de[j]) begin
            e = '0; tag = "R11";
        end else if (!a_m422[j]) begin
            e = {a_y[j], a_ca[j], a_cb[j]};
            tag = (a_dep[j] == 12) ? "R2" : "R3";
        end else if (!a_par[j]) begin
            e = {a_y[j], a_ca[j], a_ca[j+1]};
            if (j == 0 || !a_de[j-1]) tag = "R6";
            else tag = (a_dep[j] < 12) ? "R5" : "R4";
        end else begin
            cb = a_ca[j-1];
            cr = a_ca[j];
            if (!a_int[j]) tag = "R7";
            else if (a_de[j+1] && !a_par[j+1]) begin
                cb = avg(cb, a_ca[j+1]);
                cr = avg(cr, a_ca[j+2]);
                tag = "R8";
            end else tag = "R9";
            e = {a_y[j], cb, cr};
        end
    endtask

    task automatic step(input bit v, input bit de, input bit hs, input bit vs);
        int d;
        bit [11:0] lm, jy, jc, ry, rc, sy, sb, sr;
        logic [35:0] e;
        string tag;
        int j;
        @(negedge clk);
        d  = dbits(cfg_depth);
        lm = 12'((1 << (12 - d)) - 1);
        if (v) begin
            a_de[ns] = de; a_hs[ns] = hs; a_vs[ns] = vs;
            a_par[ns] = de ? par_b : 1'b0;
            par_b = de ? ~par_b : 1'b0;
            a_m422[ns] = cfg_422; a_int[ns] = cfg_interp; a_dep[ns] = d;
            a_y[ns] = '0; a_ca[ns] = '0; a_cb[ns] = '0;
            in_ch0 = 12'($urandom); in_ch1 = 12'($urandom); in_ch2 = 12'($urandom);
            if (de && cfg_422) begin
                jy = sample(d) << (12 - d);
                jc = sample(d) << (12 - d);
                ry = jy | (12'($urandom) & lm);
                rc = jc | (12'($urandom) & lm);
                in_ch0 = {4'($urandom), rc[3:0], ry[3:0]};
                in_ch1 = {4'($urandom), ry[11:4]};
                in_ch2 = {4'($urandom), rc[11:4]};
                a_y[ns] = jy; a_ca[ns] = jc;
            end else if (de) begin
                sy = sample(d); sb = sample(d); sr = sample(d);
                in_ch1 = sy | (12'($urandom) << d);
                in_ch0 = sb | (12'($urandom) << d);
                in_ch2 = sr | (12'($urandom) << d);
                a_y[ns] = sy << (12 - d); a_ca[ns] = sb << (12 - d); a_cb[ns] = sr << (12 - d);
            end
            in_de = de; in_hs = hs; in_vs = vs;
            ns++;
        end else begin
            in_de = 1'($urandom); in_hs = 1'($urandom); in_vs = 1'($urandom);
            in_ch0 = 12'($urandom); in_ch1 = 12'($urandom); in_ch2 = 12'($urandom);
        end
        in_valid = v;
        @(posedge clk);
        #5;
        if (v) begin
            check(out_valid == 1'b1, "R10", 39'(out_valid), 39'd1);
            if (ns >= 3) begin
                j = ns - 3;
                calc(j, e, tag);
                check({out_y, out_cb, out_cr} == e, tag, 39'({out_y, out_cb, out_cr}), 39'(e));
                check({out_de, out_hs, out_vs} == {a_de[j], a_hs[j], a_vs[j]}, "R10",
                      39'({out_de, out_hs, out_vs}), 39'({a_de[j], a_hs[j], a_vs[j]}));
            end
            snap = {out_de, out_hs, out_vs, out_y, out_cb, out_cr};
        end else begin
            check(out_valid == 1'b0, "R10", 39'(out_valid), 39'd0);
            check({out_de, out_hs, out_vs, out_y, out_cb, out_cr} == snap, "R12",
                  {out_de, out_hs, out_vs, out_y, out_cb, out_cr}, snap);
        end
    endtask

    task automatic line(input int len, input bit gaps);
        for (int i = 0; i < len; i++) begin
            if (gaps && ($urandom % 4 == 0)) step(1'b0, 1'b0, 1'b0, 1'b0);
            step(1'b1, 1'b1, 1'b0, 1'b0);
        end
        step(1'b1, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic segment(input bit m, input bit it, input logic [1:0] dc, input int p);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b1);
        cfg_422 = m; cfg_interp = it; cfg_depth = dc;
        step(1'b1, 1'b0, 1'b0, 1'b0);
        pat = p;
        line(2, 1'b0);
        pat = 0;
        for (int l = 0; l < 3; l++) line(2 + 2 * int'($urandom % 5), 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; in_valid = 1'b0; in_de = 1'b0; in_hs = 1'b0; in_vs = 1'b0;
        in_ch0 = '0; in_ch1 = '0; in_ch2 = '0;
        cfg_422 = 1'b0; cfg_interp = 1'b0; cfg_depth = 2'd2;
        repeat (3) @(posedge clk);
        #5;
        check({out_valid, out_de, out_hs, out_vs, out_y, out_cb, out_cr} == '0, "R1",
              39'({out_valid, out_de, out_hs, out_vs, out_y, out_cb, out_cr}), 39'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #5;
        check({out_valid, out_de, out_y, out_cb, out_cr} == '0, "R1",
              39'({out_valid, out_de, out_y, out_cb, out_cr}), 39'd0);
        snap = '0;
        segment(1'b0, 1'b0, 2'd2, 0);
        segment(1'b0, 1'b0, 2'd0, 1);
        segment(1'b0, 1'b0, 2'd1, 0);
        segment(1'b1, 1'b0, 2'd2, 0);
        segment(1'b1, 1'b1, 2'd2, 1);
        segment(1'b1, 1'b1, 2'd2, 2);
        segment(1'b1, 1'b1, 2'd0, 0);
        segment(1'b1, 1'b0, 2'd1, 2);
        segment(1'b0, 1'b0, 2'd3, 0);
        for (int s = 0; s < 6; s++)
            segment(1'($urandom), 1'($urandom), 2'($urandom), 0);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule